// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous static RAM built for buses that switch between reads and writes on every cycle. Commands are sampled on the rising clock edge. The data for a command moves on a shared bidirectional bus in the cycle that follows. Read data and write data both keep this one-cycle offset, so a write can follow a read, or a read a write, with no idle cycle between them.

Storage is an array of words split into byte lanes of nine bits. Each lane is kept separately, so a partial write touches only its own lanes. A command can start a short burst. After that, advance cycles step the two lowest address bits, either linearly or by exclusive-or with a counter. An active-high stall input freezes the whole pipeline, as if the edge had not happened. Three chip selects control a deselect cycle, and an asynchronous output enable can force the bus to high impedance at any time.

Top module: `zt_sram`

## Requirements
- R1: When `stall` is high at a rising edge, nothing changes: the bus output, the pending operation, the burst state and the array all keep their values. A write data phase that is pending is stretched to the next edge with `stall` low, and the bus value at that later edge is the one written.
- R2: The chip is selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. At an edge with `load_n`=0 and the chip selected, a new command is taken from `addr` and `wr_n` (0 = write, 1 = read). At an edge with `load_n`=0 and any other select combination, a deselect cycle starts.
- R3: A read command drives `dq` with the addressed word during the clock cycle right after its command edge. A write command takes its data from `dq` at the next edge with `stall` low.
- R4: `byte_wr_n[i]`=0 on a write or write-burst cycle writes lane i, bits 9*i+8 down to 9*i. Lanes whose enable is 1 keep their old contents.
- R5: On a read, `byte_wr_n` has no effect, and the array is not changed.
- R6: `dq` is high impedance in the cycle after a deselect, in the data phase of any write, and whenever `out_en_n` is 1.
- R7: An edge with `load_n`=1 during an active burst advances a 2-bit counter c (1, 2, 3, 0, ...). The address keeps the base's upper bits. Its two low bits are (base+c) mod 4 when `seq_linear`=1 and base XOR c when `seq_linear`=0. On such an edge `addr` and `wr_n` are ignored, and the burst keeps its read or write type.
- R8: A read whose command edge is the same edge that takes the data of a write to the same address returns the newly written lanes.
- R9: An edge with `load_n`=1 after a deselect, or after reset, is treated as a deselect.
- R10: After reset, `dq` is high impedance and no operation is pending.
- R11: Any mix of reads, writes, bursts and stalls on consecutive cycles gives the same bus values as applying each command in order to a plain word array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High freezes the block for this edge |
| addr | input | AW | Word address for a load cycle |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b | input | 1 | Active-high chip select |
| cs_c_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | 0 = write, 1 = read, taken on load cycles |
| byte_wr_n | input | LANES | Active-low write enable, one per 9-bit lane |
| load_n | input | 1 | 0 = load a new command, 1 = advance the burst |
| seq_linear | input | 1 | 1 = linear burst order, 0 = XOR burst order |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The bench checks a write followed by a read of the same address on the very next edge. A design without the bypass would return the stale word there. It stalls an edge during a pending write and changes the bus data during the stall. A design that wrote at the stalled edge would store the wrong value, and one that let the stall move its read register would change the bus. Bursts are run in both orders with `addr` and `wr_n` toggled on every advance. An address sequence built wrongly, or a burst that picked up the new read/write type, shows up as wrong data on the readback. Advance cycles after a deselect and after reset must leave the bus floating. A design that kept an old burst alive would drive it, or write into the array.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned LANES  = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_cmd_seq.sv
`timescale 1ns/1ps
// Command capture and burst address sequencer.
module zt_cmd_seq import zt_pkg::*; #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES_P = 4,
  parameter int unsigned CNT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_en,
  input  logic               load_n,
  input  logic               sel,
  input  logic               wr_n,
  input  logic               seq_linear,
  input  logic [AW-1:0]      addr,
  input  logic [LANES_P-1:0] byte_wr_n,
  output op_e                nxt_op,
  output logic [AW-1:0]      nxt_addr,
  output op_e                cur_op,
  output logic [AW-1:0]      cur_addr,
  output logic [LANES_P-1:0] cur_bw_n
);
  logic             act_q, act_d;
  logic             bwr_q, bwr_d;
  logic [AW-1:0]    base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, low_seq;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign low_seq = seq_linear ? (base_q[CNT_W-1:0] + cnt_inc)
                              : (base_q[CNT_W-1:0] ^ cnt_inc);

  always_comb begin
    act_d    = act_q;
    bwr_d    = bwr_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    nxt_op   = OP_IDLE;
    nxt_addr = addr;
    if (!load_n) begin
      if (sel) begin
        act_d  = 1'b1;
        bwr_d  = !wr_n;
        base_d = addr;
        cnt_d  = '0;
        nxt_op = wr_n ? OP_READ : OP_WRITE;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      cnt_d    = cnt_inc;
      nxt_op   = bwr_q ? OP_WRITE : OP_READ;
      nxt_addr = {base_q[AW-1:CNT_W], low_seq};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      bwr_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      cur_op   <= OP_IDLE;
      cur_addr <= '0;
      cur_bw_n <= '1;
    end else if (step_en) begin
      act_q    <= act_d;
      bwr_q    <= bwr_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      cur_op   <= nxt_op;
      cur_addr <= nxt_addr;
      cur_bw_n <= byte_wr_n;
    end
  end

  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(cur_op) && $stable(act_q)))
    else $error("pending operation moved during a stall");

  assert_deselect_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_n && !sel) |=> (cur_op == OP_IDLE))
    else $error("deselect left an operation pending");

  assert_load_write_R2: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_n && sel && !wr_n) |=> (cur_op == OP_WRITE))
    else $error("selected write load not captured");

  assert_burst_kind_R7: assert property (@(posedge clk) disable iff (rst)
    (step_en && load_n && act_q) |=> ((cur_op != OP_IDLE) && ((cur_op == OP_WRITE) == $past(bwr_q))))
    else $error("burst advance changed the operation type");

  assert_adv_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (step_en && load_n && !act_q) |=> (cur_op == OP_IDLE))
    else $error("advance without a burst started an operation");
endmodule

// File: rtl/zt_lane_mem.sv
`timescale 1ns/1ps
// One byte lane of storage, synchronous read with write bypass.
module zt_lane_mem #(
  parameter int unsigned AW     = 6,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [AW-1:0]     wr_addr,
  input  logic [LANE_W-1:0] wr_data,
  input  logic              rd,
  input  logic [AW-1:0]     rd_addr,
  output logic [LANE_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[wr_addr] <= wr_data;
    if (rd) rd_data <= (wr && (wr_addr == rd_addr)) ? wr_data : mem[rd_addr];
  end
endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
// Word array made of independent byte lanes.
module zt_array import zt_pkg::*; #(
  parameter int unsigned AW      = 6,
  parameter int unsigned LANE_W_P = 9,
  parameter int unsigned LANES_P = 4
) (
  input  logic                        clk,
  input  logic                        step_en,
  input  op_e                         cur_op,
  input  logic [AW-1:0]               cur_addr,
  input  logic [LANES_P-1:0]          cur_bw_n,
  input  logic [LANES_P*LANE_W_P-1:0] bus_in,
  input  op_e                         nxt_op,
  input  logic [AW-1:0]               nxt_addr,
  output logic [LANES_P*LANE_W_P-1:0] rd_word
);
  logic do_rd;
  assign do_rd = step_en && (nxt_op == OP_READ);

  for (genvar g = 0; g < LANES_P; g++) begin : g_lane
    logic lane_wr;
    assign lane_wr = step_en && (cur_op == OP_WRITE) && !cur_bw_n[g];

    zt_lane_mem #(.AW(AW), .LANE_W(LANE_W_P)) u_lane (
      .clk     (clk),
      .wr      (lane_wr),
      .wr_addr (cur_addr),
      .wr_data (bus_in[g*LANE_W_P +: LANE_W_P]),
      .rd      (do_rd),
      .rd_addr (nxt_addr),
      .rd_data (rd_word[g*LANE_W_P +: LANE_W_P])
    );
  end
endmodule

// File: rtl/zt_io.sv
`timescale 1ns/1ps
// Bus drive control for the data phase.
module zt_io import zt_pkg::*; #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  op_e          nxt_op,
  input  logic         out_en_n,
  input  logic [W-1:0] rd_word,
  output logic [W-1:0] dq_o,
  output logic         dq_oe
);
  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst)          drive_q <= 1'b0;
    else if (step_en) drive_q <= (nxt_op == OP_READ);
  end

  assign dq_o  = rd_word;
  assign dq_oe = drive_q && !out_en_n;

  assert_stall_drive_R1: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(drive_q))
    else $error("bus drive changed during a stall");

  assert_read_drive_R3: assert property (@(posedge clk) disable iff (rst)
    (step_en && nxt_op == OP_READ) |=> drive_q)
    else $error("read data phase not driven");

  assert_write_float_R6: assert property (@(posedge clk) disable iff (rst)
    (step_en && nxt_op != OP_READ) |=> !drive_q)
    else $error("bus driven outside a read data phase");
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
// Zero-turnaround synchronous SRAM, top level.
module zt_sram import zt_pkg::*; #(
  parameter int unsigned AW       = 6,
  parameter int unsigned LANE_W_P = LANE_W,
  parameter int unsigned LANES_P  = LANES,
  parameter int unsigned CNT_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        stall,
  input  logic [AW-1:0]               addr,
  input  logic                        cs_a_n,
  input  logic                        cs_b,
  input  logic                        cs_c_n,
  input  logic                        wr_n,
  input  logic [LANES_P-1:0]          byte_wr_n,
  input  logic                        load_n,
  input  logic                        seq_linear,
  input  logic                        out_en_n,
  inout  wire  [LANES_P*LANE_W_P-1:0] dq
);
  localparam int unsigned W = LANES_P * LANE_W_P;

  logic               step_en, sel;
  op_e                nxt_op, cur_op;
  logic [AW-1:0]      nxt_addr, cur_addr;
  logic [LANES_P-1:0] cur_bw_n;
  logic [W-1:0]       rd_word, dq_o;
  logic               dq_oe;

  assign step_en = !stall;
  assign sel     = !cs_a_n && cs_b && !cs_c_n;

  zt_cmd_seq #(.AW(AW), .LANES_P(LANES_P), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .step_en(step_en), .load_n(load_n), .sel(sel),
    .wr_n(wr_n), .seq_linear(seq_linear), .addr(addr), .byte_wr_n(byte_wr_n),
    .nxt_op(nxt_op), .nxt_addr(nxt_addr), .cur_op(cur_op),
    .cur_addr(cur_addr), .cur_bw_n(cur_bw_n)
  );

  zt_array #(.AW(AW), .LANE_W_P(LANE_W_P), .LANES_P(LANES_P)) u_array (
    .clk(clk), .step_en(step_en), .cur_op(cur_op), .cur_addr(cur_addr),
    .cur_bw_n(cur_bw_n), .bus_in(dq), .nxt_op(nxt_op), .nxt_addr(nxt_addr),
    .rd_word(rd_word)
  );

  zt_io #(.W(W)) u_io (
    .clk(clk), .rst(rst), .step_en(step_en), .nxt_op(nxt_op),
    .out_en_n(out_en_n), .rd_word(rd_word), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  assign dq = dq_oe ? dq_o : {W{1'bz}};
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  localparam int AW = 6;
  localparam int W = 36;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, stall, cs_a_n, cs_b, cs_c_n, wr_n, load_n, seq_linear, out_en_n;
  logic [AW-1:0] addr;
  logic [3:0] bw_n;
  logic tb_drv;
  logic [W-1:0] tb_dq, pend_wd;
  wire  [W-1:0] dq;
  assign dq = tb_drv ? tb_dq : {W{1'bz}};

  zt_sram u_dut (
    .clk(clk), .rst(rst), .stall(stall), .addr(addr), .cs_a_n(cs_a_n),
    .cs_b(cs_b), .cs_c_n(cs_c_n), .wr_n(wr_n), .byte_wr_n(bw_n),
    .load_n(load_n), .seq_linear(seq_linear), .out_en_n(out_en_n), .dq(dq)
  );

  // behavioural reference
  logic [W-1:0] m_mem [DEPTH];
  bit m_pv, m_pw, m_act, m_bwr, m_drv;
  int m_pa, m_base, m_cnt;
  logic [3:0] m_pbw;
  logic [W-1:0] m_rd;
  int n_run = 0, n_fail = 0;
  string cur_req = "R10";

  task automatic model_edge();
    bit nv, nw, sel;
    int na;
    if (rst) begin
      m_pv = 0; m_pw = 0; m_act = 0; m_drv = 0;
    end else if (!stall) begin
      if (m_pv && m_pw)
        for (int l = 0; l < 4; l++)
          if (!m_pbw[l]) m_mem[m_pa][l*9 +: 9] = tb_dq[l*9 +: 9];
      nv = 0; nw = 0; na = 0;
      sel = !cs_a_n && cs_b && !cs_c_n;
      if (!load_n) begin
        if (sel) begin
          m_act = 1; m_bwr = !wr_n; m_base = int'(addr); m_cnt = 0;
          nv = 1; nw = !wr_n; na = int'(addr);
        end else m_act = 0;
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4;
        nv = 1; nw = m_bwr;
        na = (m_base & ~3) | (seq_linear ? ((m_base + m_cnt) % 4) : ((m_base ^ m_cnt) & 3));
      end
      m_pv = nv; m_pw = nw; m_pa = na; m_pbw = bw_n;
      m_drv = nv && !nw;
      if (m_drv) m_rd = m_mem[na];
    end
  endtask

  task automatic check();
    logic [W-1:0] exp;
    exp = (m_drv && !out_en_n) ? m_rd : (tb_drv ? tb_dq : {W{1'bz}});
    n_run++;
    if (dq !== exp) begin
      n_fail++;
      $display("FAIL %s: dq=%h expected %h", cur_req, dq, exp);
    end
  endtask

  // cs: 0 selected, 1 cs_a_n high, 2 cs_b low, 3 cs_c_n high
  task automatic step(input bit st, input int cs, input bit ld_n, input bit w_n,
                      input int a, input logic [3:0] b, input bit oe);
    stall = st; cs_a_n = (cs == 1); cs_b = (cs != 2); cs_c_n = (cs == 3);
    load_n = ld_n; wr_n = w_n; addr = AW'(a); bw_n = b; out_en_n = oe;
    tb_dq = pend_wd;
    @(posedge clk);
    model_edge();
    #1;
    tb_drv = m_pv && m_pw;
    @(negedge clk);
    check();
  endtask

  task automatic wr(input int a, input logic [W-1:0] d, input logic [3:0] b);
    step(0, 0, 0, 0, a, b, 0);
    pend_wd = d;
  endtask
  task automatic rd(input int a, input bit oe);
    step(0, 0, 0, 1, a, 4'($urandom), oe);
  endtask
  task automatic desel(input int cs);
    step(0, cs, 0, 1, 0, 4'hF, 0);
  endtask
  task automatic adv(input logic [W-1:0] d);
    step(0, 0, 1, 1'($urandom), int'($urandom % 64), 4'h0, 0);
    pend_wd = d;
  endtask
  task automatic stl();
    step(1, int'($urandom % 4), 1'($urandom), 1'($urandom), int'($urandom % 64), 4'($urandom), 0);
  endtask

  function automatic logic [W-1:0] rnd();
    return {4'($urandom), $urandom};
  endfunction

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; tb_drv = 0; pend_wd = '0; seq_linear = 1;
    stall = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0; wr_n = 1; load_n = 1;
    addr = '0; bw_n = '1; out_en_n = 0; tb_dq = '0;
    @(negedge clk);
    cur_req = "R10";
    step(0, 0, 0, 1, 3, 4'h0, 0);
    step(0, 0, 0, 1, 3, 4'h0, 0);
    rst = 0;
    cur_req = "R9";               // advance right after reset
    step(0, 0, 1, 0, 2, 4'h0, 0);
    step(0, 0, 1, 1, 2, 4'h0, 0);

    cur_req = "R3";               // fill every word, back to back
    for (int a = 0; a < DEPTH; a++) wr(a, rnd(), 4'h0);
    for (int a = 0; a < 8; a++) rd(a, 0);

    cur_req = "R11";              // alternating directions
    wr(10, rnd(), 4'h0); rd(11, 0); wr(12, rnd(), 4'h0); rd(10, 0); rd(12, 0);

    cur_req = "R8";               // read follows write to same word
    wr(20, rnd(), 4'h0); rd(20, 0);
    wr(21, rnd(), 4'h0); rd(21, 0); rd(21, 0);

    cur_req = "R4";               // partial lanes
    wr(22, rnd(), 4'b1010); rd(22, 0);
    wr(23, rnd(), 4'b0111); rd(24, 0); rd(23, 0);

    cur_req = "R5";               // byte enables low on reads
    rd(25, 0); step(0, 0, 0, 1, 25, 4'h0, 0); rd(25, 0);

    cur_req = "R2";
    for (int c = 1; c < 4; c++) begin rd(5, 0); desel(c); end
    rd(6, 0);

    cur_req = "R6";
    rd(5, 1); rd(6, 0); wr(7, rnd(), 4'h0); desel(2); rd(7, 0); desel(1);

    cur_req = "R7";               // linear then xor bursts
    seq_linear = 1;
    wr(33, rnd(), 4'h0); adv(rnd()); adv(rnd()); adv(rnd()); adv(rnd());
    desel(3);
    rd(33, 0); step(0, 0, 1, 0, 9, 4'h0, 0); step(0, 0, 1, 0, 9, 4'h0, 0);
    step(0, 0, 1, 0, 9, 4'h0, 0);
    seq_linear = 0;
    rd(46, 0); step(0, 0, 1, 0, 1, 4'h0, 0); step(0, 0, 1, 0, 1, 4'h0, 0);
    step(0, 0, 1, 0, 1, 4'h0, 0);
    wr(45, rnd(), 4'h0); adv(rnd()); adv(rnd()); adv(rnd());
    rd(44, 0); rd(45, 0); rd(46, 0); rd(47, 0);

    cur_req = "R9";
    desel(1); step(0, 0, 1, 0, 3, 4'h0, 0); step(0, 0, 1, 1, 3, 4'h0, 0); rd(3, 0);

    cur_req = "R1";
    rd(7, 0); stl(); stl(); rd(8, 0);
    wr(8, rnd(), 4'h0); stl(); pend_wd = rnd(); stl(); pend_wd = rnd();
    rd(8, 0); rd(8, 0);

    cur_req = "R11";              // free mix
    for (int i = 0; i < 500; i++) begin
      int k;
      k = int'($urandom % 20);
      pend_wd = rnd();
      seq_linear = 1'($urandom);
      if (k < 3)       stl();
      else if (k < 5)  desel(1 + int'($urandom % 3));
      else if (k < 9)  step(0, 0, 1, 1'($urandom), int'($urandom % 64), 4'($urandom), 0);
      else if (k < 14) step(0, 0, 0, 0, int'($urandom % 64), 4'($urandom), 0);
      else             step(0, 0, 0, 1, int'($urandom % 64), 4'($urandom), ($urandom % 10) == 0);
    end
    desel(1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule